// File: doc/BRIEF.md
# I2C Write-Only Display Command Receiver

This block is an I2C slave that accepts writes only, and it sits in front of a small display controller. SCL and SDA arrive from the pads, pass through synchronisers and are sampled on the system clock. The block drives SDA through an open-drain output enable and never puts a high level on the wire. After a START it compares the first byte with its own 7-bit address. The upper six address bits are fixed. The lowest bit comes from a strap pin, so two receivers can share one bus.

An accepted transfer opens with one or more command bytes. The top bit of each command byte tells the receiver whether another command follows. Once a command with that bit clear has arrived, every later byte in the transfer is display data. Each command is reported as a 7-bit code with a one-cycle strobe. Each data byte goes to an external display RAM through a write port. The RAM address is a column pointer combined with a row counter, and it advances on its own after every stored byte. A command whose code selects a column loads the column pointer and clears the row counter.

Top module: `dispwr_i2c_rx`

## Requirements
- R1: After reset, `sda_oe`, `cmd_valid` and `ram_we` are low, and the pointer is column 0, row 0 (`ram_addr` = 0).
- R2: An address byte whose bits [7:1] equal 011110 followed by `addr_lsb`, and whose bit 0 is 0, is acknowledged. Any other address byte is not acknowledged. The block then acknowledges nothing, stores nothing and strobes nothing until the next START.
- R3: An address byte that matches but has bit 0 (read) set to 1 is not acknowledged, and the rest of that transfer is ignored.
- R4: Bit 7 of a command byte is the continuation flag. Bits [6:0] appear on `cmd_code` with `cmd_valid` high for exactly one cycle. While the flag is 1 the next byte is another command. After a command with the flag at 0, every byte is data, whatever its bit 7.
- R5: Each data byte is acknowledged and stored with a one-cycle `ram_we` pulse. `ram_data` carries the byte. `ram_addr` = column × 2^YW + row, where YW = clog2(ROWS). The pulse occurs while SCL is high in that byte's acknowledge clock. Command strobes follow the same rule.
- R6: After each stored byte the row counter increments. When it passes ROWS-1 it returns to 0 and the column increments. The column wraps from COLS-1 to 0.
- R7: A command with bit 6 set also loads the column pointer from bits [5:0] and clears the row counter. A value of COLS or more loads column 0.
- R8: SDA is pulled low only from the SCL falling edge that follows the 8th bit of an acknowledged byte until the next SCL falling edge. During the data bits SDA is released.
- R9: A repeated START returns the receiver to the address phase. STOP ends the transfer. The pointer keeps its value across transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL from the pad |
| sda_in | input | 1 | Raw SDA from the pad |
| addr_lsb | input | 1 | Strap that sets address bit 0 |
| sda_oe | output | 1 | When high, SDA is pulled low |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_code | output | 7 | Command code (bits [6:0] of the command byte) |
| ram_we | output | 1 | Display RAM write enable, one cycle per byte |
| ram_addr | output | XW+YW | Display RAM address {column, row} |
| ram_data | output | 8 | Display byte to store |

## Verification
A store can coincide with both wraps: the row counter passes ROWS-1 and the column passes COLS-1 on the same advance. The bench provokes this by loading the last column through a command and then streaming six data bytes. It also sweeps every 6-bit column-load value followed by one data byte. In both cases the recorded write addresses are compared with a pointer model in the bench that does the wrap arithmetic itself. The bench also checks that each write pulse falls inside the acknowledge clock, with SCL high and SDA held low.

// File: rtl/dispwr_pkg.sv
package dispwr_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CMD,
      PH_DATA,
      PH_SKIP
   } phase_t;

   localparam logic [5:0] DEV_ADDR_HI = 6'b011110;
   localparam int         BYTE_BITS   = 8;
   localparam int         COL_FIELD_W = 6;
endpackage

// File: rtl/dispwr_sync.sv
module dispwr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("dispwr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/dispwr_cond.sv
module dispwr_cond (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_q,
   input  logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_q;
         sda_d <= sda_q;
      end
   end

   assign scl_rise  = scl_q & ~scl_d;
   assign scl_fall  = ~scl_q & scl_d;
   assign bus_start = scl_q & scl_d & sda_d & ~sda_q;
   assign bus_stop  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/dispwr_ptr.sv
module dispwr_ptr #(
   parameter int ROWS = 4,
   parameter int COLS = 40,
   parameter int XW   = 6,
   parameter int YW   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          load,
   input  logic [5:0]    load_val,
   output logic [XW-1:0] col,
   output logic [YW-1:0] row
);
   logic row_wrap;
   logic [XW-1:0] col_inc;

   generate
      if (ROWS == (1 << YW)) begin : g_row_pow2
         assign row_wrap = &row;
      end else begin : g_row_cmp
         assign row_wrap = (row == YW'(ROWS - 1));
      end
   endgenerate

   assign col_inc = (col == XW'(COLS - 1)) ? '0 : col + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col <= '0;
         row <= '0;
      end else if (load) begin
         row <= '0;
         col <= (int'(load_val) < COLS) ? XW'(load_val) : '0;
      end else if (adv) begin
         if (row_wrap) begin
            row <= '0;
            col <= col_inc;
         end else begin
            row <= row + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dispwr_i2c_rx.sv
module dispwr_i2c_rx
   import dispwr_pkg::*;
#(
   parameter int ROWS        = 4,
   parameter int COLS        = 40,
   parameter int SYNC_STAGES = 2,
   localparam int YW = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int XW = (COLS > 1) ? $clog2(COLS) : 1,
   localparam int AW = XW + YW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_in,
   input  logic          sda_in,
   input  logic          addr_lsb,
   output logic          sda_oe,
   output logic          cmd_valid,
   output logic [6:0]    cmd_code,
   output logic          ram_we,
   output logic [AW-1:0] ram_addr,
   output logic [7:0]    ram_data
);
   generate
      if (ROWS < 2) begin : g_rows_chk
         $error("dispwr_i2c_rx: ROWS must be at least 2");
      end
      if (COLS < 2 || COLS > (1 << COL_FIELD_W)) begin : g_cols_chk
         $error("dispwr_i2c_rx: COLS must lie in 2..64");
      end
   endgenerate

   logic scl_q, sda_q;
   logic scl_rise, scl_fall, bus_start, bus_stop;

   dispwr_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .din(scl_in), .dout(scl_q));
   dispwr_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_q));

   dispwr_cond u_cond (
      .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_q(sda_q),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop));

   phase_t     phase;
   logic [3:0] bitcnt;
   logic [7:0] shreg;
   logic       active, addr_hit, take_byte, exec;
   logic [XW-1:0] col;
   logic [YW-1:0] row;

   assign active    = (phase == PH_ADDR) || (phase == PH_CMD) || (phase == PH_DATA);
   assign addr_hit  = (shreg[7:1] == {DEV_ADDR_HI, addr_lsb}) && !shreg[0];
   assign take_byte = (phase != PH_ADDR) || addr_hit;
   assign exec      = active && scl_rise && (bitcnt == 4'd9) && !bus_start && !bus_stop;

   dispwr_ptr #(.ROWS(ROWS), .COLS(COLS), .XW(XW), .YW(YW)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .adv(exec && (phase == PH_DATA)),
      .load(exec && (phase == PH_CMD) && shreg[6]),
      .load_val(shreg[5:0]),
      .col(col), .row(row));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         bitcnt    <= '0;
         shreg     <= '0;
         sda_oe    <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_code  <= '0;
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_data  <= '0;
      end else begin
         cmd_valid <= 1'b0;
         ram_we    <= 1'b0;
         if (bus_start) begin
            phase  <= PH_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (bus_stop) begin
            phase  <= PH_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (active) begin
            if (scl_rise && bitcnt < 4'd8) begin
               shreg  <= {shreg[6:0], sda_q};
               bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
               if (take_byte) begin
                  sda_oe <= 1'b1;
                  bitcnt <= 4'd9;
               end else begin
                  phase  <= PH_SKIP;
                  bitcnt <= '0;
               end
            end else if (exec) begin
               unique case (phase)
                  PH_ADDR: phase <= PH_CMD;
                  PH_CMD: begin
                     cmd_valid <= 1'b1;
                     cmd_code  <= shreg[6:0];
                     if (!shreg[7]) phase <= PH_DATA;
                  end
                  default: begin
                     ram_we   <= 1'b1;
                     ram_addr <= {col, row};
                     ram_data <= shreg;
                  end
               endcase
            end else if (scl_fall && bitcnt == 4'd9) begin
               sda_oe <= 1'b0;
               bitcnt <= '0;
            end
         end
      end
   end
endmodule

// File: rtl/dispwr_chk.sv
module dispwr_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_q,
   input logic sda_oe,
   input logic cmd_valid,
   input logic ram_we
);
   // R8
   oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_q);

   // R5
   we_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (sda_oe && scl_q));

   // R4
   cmd_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> (sda_oe && scl_q));

   // R4
   cmd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

   // R5
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> !ram_we);

   // R4
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cmd_valid, ram_we}));
endmodule

bind dispwr_i2c_rx dispwr_chk chk_i (
   .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .sda_oe(sda_oe),
   .cmd_valid(cmd_valid), .ram_we(ram_we));

// File: tb/dispwr_i2c_rx_tb.sv
module dispwr_i2c_rx_tb_top;
   localparam int ROWS = 4;
   localparam int COLS = 40;
   localparam int YW   = 2;
   localparam int XW   = 6;
   localparam int Q    = 6;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic scl_b = 1'b1, sda_b = 1'b1, strap = 1'b0;
   logic sda_oe, cmd_valid, ram_we;
   logic [6:0] cmd_code;
   logic [XW+YW-1:0] ram_addr;
   logic [7:0] ram_data;
   wire sda_line = sda_b & ~sda_oe;

   dispwr_i2c_rx #(.ROWS(ROWS), .COLS(COLS), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_b), .sda_in(sda_line),
      .addr_lsb(strap), .sda_oe(sda_oe), .cmd_valid(cmd_valid),
      .cmd_code(cmd_code), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_data(ram_data));

   int n_chk = 0, n_bad = 0;
   int rec_a[256], rec_d[256], n_rec = 0;
   int rec_c[64], n_rc = 0;
   int exp_a[256], exp_d[256], n_exp = 0;
   int exp_c[64], n_ec = 0;
   int ex = 0, ey = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic wq(input int n);
      repeat (n) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (ram_we) begin
            if (n_rec < 256) begin
               rec_a[n_rec] = int'(ram_addr);
               rec_d[n_rec] = int'(ram_data);
            end
            n_rec++;
            // R5: write lands inside the acknowledge clock
            chk(scl_b && !sda_line, "R5 ack-window", {30'd0, scl_b, sda_line}, 2);
         end
         if (cmd_valid) begin
            if (n_rc < 64) rec_c[n_rc] = int'(cmd_code);
            n_rc++;
         end
      end
   end

   task automatic m_load(input int v);
      ex = (v < COLS) ? v : 0;
      ey = 0;
   endtask

   task automatic m_cmd(input logic [7:0] b);
      exp_c[n_ec] = int'(b[6:0]);
      n_ec++;
      if (b[6]) m_load(int'(b[5:0]));
   endtask

   task automatic m_write(input int d);
      exp_a[n_exp] = ex * (1 << YW) + ey;
      exp_d[n_exp] = d;
      n_exp++;
      ey++;
      if (ey == ROWS) begin
         ey = 0;
         ex = (ex + 1) % COLS;
      end
   endtask

   task automatic bus_start;
      wq(Q); sda_b = 1'b1;
      wq(Q); scl_b = 1'b1;
      wq(Q); sda_b = 1'b0;
      wq(Q); scl_b = 1'b0;
   endtask

   task automatic bus_stop;
      wq(Q); sda_b = 1'b0;
      wq(Q); scl_b = 1'b1;
      wq(Q); sda_b = 1'b1;
      wq(2 * Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
      for (int i = 7; i >= 0; i--) begin
         wq(Q); sda_b = b[i];
         wq(Q); scl_b = 1'b1;
         wq(Q);
         // R8: SDA released while data bits are on the wire
         chk(sda_line == b[i], "R8 data-bit", int'(sda_line), int'(b[i]));
         wq(Q); scl_b = 1'b0;
      end
      wq(Q); sda_b = 1'b1;
      wq(Q); scl_b = 1'b1;
      wq(Q);
      chk((sda_line == 1'b0) == exp_ack, req, int'(sda_line), exp_ack ? 0 : 1);
      wq(Q); scl_b = 1'b0;
   endtask

   task automatic send_cmd(input logic [7:0] b);
      send_byte(b, 1'b1, "R4 cmd-ack");
      m_cmd(b);
   endtask

   task automatic send_data(input int n, input int base);
      for (int i = 0; i < n; i++) begin
         send_byte(8'((base + i) & 255), 1'b1, "R5 data-ack");
         m_write((base + i) & 255);
      end
   endtask

   task automatic verify(input string req);
      wq(4);
      chk(n_rec == n_exp, {req, " write-count"}, n_rec, n_exp);
      for (int i = 0; i < n_exp && i < n_rec; i++) begin
         chk(rec_a[i] == exp_a[i], {req, " addr"}, rec_a[i], exp_a[i]);
         chk(rec_d[i] == exp_d[i], {req, " data"}, rec_d[i], exp_d[i]);
      end
      chk(n_rc == n_ec, {req, " cmd-count"}, n_rc, n_ec);
      for (int i = 0; i < n_ec && i < n_rc; i++)
         chk(rec_c[i] == exp_c[i], {req, " cmd-code"}, rec_c[i], exp_c[i]);
      n_rec = 0; n_exp = 0; n_rc = 0; n_ec = 0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      wq(5);
      // R1 reset state
      chk(!sda_oe && !cmd_valid && !ram_we, "R1 strobes", {29'd0, sda_oe, cmd_valid, ram_we}, 0);
      chk(ram_addr == 0, "R1 pointer", int'(ram_addr), 0);
      rst_n = 1'b1;
      wq(10);

      // R2 R4 R5 R6 R7: column load, second command, stream across rows
      bus_start;
      send_byte(8'h78, 1'b1, "R2 addr-ack");
      send_cmd(8'hC3);
      send_cmd(8'h05);
      send_data(10, 8'hA0);
      bus_stop;
      verify("R6");

      // R9: pointer kept across transfers
      bus_start;
      send_byte(8'h78, 1'b1, "R2 addr-ack");
      send_cmd(8'h12);
      send_data(3, 8'h30);
      bus_stop;
      verify("R9 persist");

      // R2: wrong address ignored
      bus_start;
      send_byte(8'h7A, 1'b0, "R2 addr-nack");
      send_byte(8'h05, 1'b0, "R2 ignored");
      send_byte(8'h11, 1'b0, "R2 ignored");
      bus_stop;
      verify("R2 ignored");

      // R3: read refused
      bus_start;
      send_byte(8'h79, 1'b0, "R3 read-nack");
      send_byte(8'h05, 1'b0, "R3 ignored");
      bus_stop;
      verify("R3");

      // R2 with strap high, R6 double wrap
      strap = 1'b1;
      bus_start;
      send_byte(8'h78, 1'b0, "R2 strap-nack");
      bus_stop;
      bus_start;
      send_byte(8'h7A, 1'b1, "R2 strap-ack");
      send_cmd(8'h67);
      send_data(6, 8'hF0);
      bus_stop;
      verify("R6 wrap");

      // R7: out-of-range column load
      bus_start;
      send_byte(8'h7A, 1'b1, "R2 strap-ack");
      send_cmd(8'h7F);
      send_data(2, 8'h55);
      bus_stop;
      verify("R7 range");

      // R9: repeated START back to address phase
      bus_start;
      send_byte(8'h7A, 1'b1, "R2 addr-ack");
      send_cmd(8'h41);
      send_data(2, 8'h81);
      bus_start;
      send_byte(8'h7C, 1'b0, "R9 rs-nack");
      send_byte(8'h99, 1'b0, "R9 ignored");
      bus_start;
      send_byte(8'h7A, 1'b1, "R9 rs-ack");
      send_cmd(8'h42);
      send_data(1, 8'h66);
      bus_stop;
      verify("R9 restart");

      // R7 sweep of every 6-bit column field
      for (int v = 0; v < 64; v++) begin
         bus_start;
         send_byte(8'h7A, 1'b1, "R2 addr-ack");
         send_cmd(8'h40 | 8'(v));
         send_data(1, v + 7);
         bus_stop;
      end
      verify("R7 sweep");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule